// File: doc/BRIEF.md
# Power-Fail Write-Protect Sequencer

This block is the digital half of a supply supervisor. Two external voltage comparators report, as level flags, that the main supply has fallen below the fail threshold (`pfail_i`) and that it has fallen further, below the level at which the battery should take over (`swover_i`). Each flag passes through a two-flop synchronizer. The synchronized flags then drive one four-state sequencer.

The sequencer produces every protective control from its state:
- a register-access block for the on-chip clock registers;
- an active-high reset output;
- a forced-high (inactive) external memory chip-enable;
- a battery-select control;
- an output-drive enable, which is low while the outputs must float.

When the supply comes back, protection stays in place for `REC_CYCLES` clock cycles of recovery and is then released. A new failure during recovery cancels the count. The next recovery starts again from the full length.

Top module: `pwr_guard`

## Requirements
- R1: While `rst_ni` is low, `state_o` is NORMAL (encoding 0), `reg_block_o`, `rst_o` and `bat_sel_o` are 0, `out_en_o` is 1, and `mem_ce_n_o` equals `mem_ce_n_i`.
- R2: A power-fail flag that is held high moves `state_o` out of NORMAL and sets `reg_block_o` on the third rising clock edge after the flag is sampled high. With the switchover flag low, the state entered is PROTECT (encoding 1). `reg_block_o` is 1 in every state other than NORMAL.
- R3: `rst_o` is 1 in every state other than NORMAL, including the whole recovery interval.
- R4: `mem_ce_n_o` is forced to 1 in every state other than NORMAL. In NORMAL it follows `mem_ce_n_i`.
- R5: A switchover flag that is held high moves the state to BATTERY (encoding 2) through the same three-edge path, from any state. `bat_sel_o` is 1 only in BATTERY.
- R6: `out_en_o` is 0 in BATTERY and 1 in every other state.
- R7: When both synchronized flags are low in PROTECT or BATTERY, the state goes to RECOVER (encoding 3). It stays there exactly `REC_CYCLES` cycles with all protection held, and then returns to NORMAL. NORMAL is entered only from RECOVER or by reset.
- R8: If the synchronized power-fail flag is high during RECOVER, the state returns to PROTECT. The next recovery again lasts the full `REC_CYCLES` cycles.
- R9: When the synchronized switchover flag clears, `bat_sel_o` drops on the next edge, even if power-fail is still high. The state then goes to PROTECT if power-fail is still high, or to RECOVER if it is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Free-running clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pfail_i | input | 1 | Comparator flag: supply below fail threshold (async) |
| swover_i | input | 1 | Comparator flag: supply below switchover level (async) |
| mem_ce_n_i | input | 1 | Requested external memory chip-enable, active low |
| reg_block_o | output | 1 | Inhibits clock-register reads and writes |
| rst_o | output | 1 | Reset output, active high |
| mem_ce_n_o | output | 1 | Gated external memory chip-enable, active low |
| bat_sel_o | output | 1 | Selects the battery as the power source |
| out_en_o | output | 1 | Output-drive enable; 0 floats the ordinary outputs |
| state_o | output | 2 | Sequencer state: 0 NORMAL, 1 PROTECT, 2 BATTERY, 3 RECOVER |

## Verification
The hardest situations to reach from the ports are two:
- a power-fail that returns part-way through the recovery count;
- a switchover flag that clears while power-fail is still held.

Both require flag edges placed relative to a count that is hidden behind a two-flop delay. Directed sequences hold power-fail long enough to enter RECOVER, wait part of the interval and pulse it again. They then measure the full length of the following recovery, and they separately release switchover ahead of power-fail. Random segments with hold times from one to thirty cycles, some shorter than the synchronizer latency, then hit these transitions many more times against a cycle-accurate reference model.

// File: rtl/pwr_guard_pkg.sv
package pwr_guard_pkg;
  typedef enum logic [1:0] {
    ST_NORMAL  = 2'd0,
    ST_PROTECT = 2'd1,
    ST_BATTERY = 2'd2,
    ST_RECOVER = 2'd3
  } pg_state_e;
endpackage

// File: rtl/pwr_guard_sync.sv
module pwr_guard_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [STAGES-1:0][WIDTH-1:0] pipe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pipe_q[0] <= '0;
    else         pipe_q[0] <= d_i;
  end

  for (genvar g = 1; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) pipe_q[g] <= '0;
      else         pipe_q[g] <= pipe_q[g-1];
    end
  end

  assign q_o = pipe_q[STAGES-1];
endmodule

// File: rtl/pwr_guard_rec_cnt.sv
module pwr_guard_rec_cnt #(
  parameter int REC_CYCLES = 20,
  parameter int CNT_W      = $clog2(REC_CYCLES + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  input  logic dec_i,
  output logic done_o
);
  localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(REC_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      cnt_q <= '0;
    else if (load_i)                  cnt_q <= LOAD_VAL;
    else if (dec_i && cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign done_o = (cnt_q == '0);
endmodule

// File: rtl/pwr_guard_fsm.sv
module pwr_guard_fsm
  import pwr_guard_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      pf_i,
  input  logic      so_i,
  input  logic      rec_done_i,
  output pg_state_e state_o,
  output logic      rec_load_o,
  output logic      rec_dec_o
);
  pg_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_NORMAL: begin
        if (so_i)      state_d = ST_BATTERY;
        else if (pf_i) state_d = ST_PROTECT;
      end
      ST_PROTECT: begin
        if (so_i)       state_d = ST_BATTERY;
        else if (!pf_i) state_d = ST_RECOVER;
      end
      ST_BATTERY: begin
        if (!so_i) state_d = pf_i ? ST_PROTECT : ST_RECOVER;
      end
      ST_RECOVER: begin
        // a fresh failure cancels the count
        if (so_i)            state_d = ST_BATTERY;
        else if (pf_i)       state_d = ST_PROTECT;
        else if (rec_done_i) state_d = ST_NORMAL;
      end
      default: state_d = ST_PROTECT;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_NORMAL;
    else         state_q <= state_d;
  end

  assign rec_load_o = (state_d == ST_RECOVER) && (state_q != ST_RECOVER);
  assign rec_dec_o  = (state_q == ST_RECOVER);
  assign state_o    = state_q;
endmodule

// File: rtl/pwr_guard.sv
module pwr_guard
  import pwr_guard_pkg::*;
#(
  parameter int REC_CYCLES  = 20,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       pfail_i,
  input  logic       swover_i,
  input  logic       mem_ce_n_i,
  output logic       reg_block_o,
  output logic       rst_o,
  output logic       mem_ce_n_o,
  output logic       bat_sel_o,
  output logic       out_en_o,
  output logic [1:0] state_o
);
  localparam int CNT_W = $clog2(REC_CYCLES + 1);

  logic [1:0] flags_s;
  logic       rec_load, rec_dec, rec_done;
  pg_state_e  state;

  pwr_guard_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({swover_i, pfail_i}),
    .q_o   (flags_s)
  );

  pwr_guard_fsm u_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .pf_i      (flags_s[0]),
    .so_i      (flags_s[1]),
    .rec_done_i(rec_done),
    .state_o   (state),
    .rec_load_o(rec_load),
    .rec_dec_o (rec_dec)
  );

  pwr_guard_rec_cnt #(.REC_CYCLES(REC_CYCLES), .CNT_W(CNT_W)) u_cnt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(rec_load),
    .dec_i (rec_dec),
    .done_o(rec_done)
  );

  logic protect;
  assign protect     = (state != ST_NORMAL);
  assign reg_block_o = protect;
  assign rst_o       = protect;
  assign mem_ce_n_o  = protect | mem_ce_n_i;
  assign bat_sel_o   = (state == ST_BATTERY);
  assign out_en_o    = (state != ST_BATTERY);
  assign state_o     = state;
endmodule

// File: rtl/pwr_guard_chk.sv
module pwr_guard_chk #(
  parameter int REC_CYCLES = 20
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       reg_block_o,
  input logic       rst_o,
  input logic       mem_ce_n_o,
  input logic       bat_sel_o,
  input logic       out_en_o,
  input logic [1:0] state_o
);
  localparam int RW = $clog2(REC_CYCLES + 2) + 1;

  logic [RW-1:0] rec_run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              rec_run_q <= '0;
    else if (state_o == 2'd3) rec_run_q <= rec_run_q + 1'b1;
    else                      rec_run_q <= '0;
  end

  a_r4_ce_forced: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_o |-> mem_ce_n_o);

  a_r2_block_with_reset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_block_o |-> rst_o);

  a_r6_float_in_battery: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bat_sel_o |-> !out_en_o);

  a_r5_bat_only_battery: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bat_sel_o |-> state_o == 2'd2);

  a_r7_normal_via_recover: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 2'd0 && $past(state_o) != 2'd0) |-> $past(state_o) == 2'd3);

  a_r7_full_interval: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 2'd0 && rec_run_q != '0) |-> rec_run_q == RW'(REC_CYCLES));
endmodule

bind pwr_guard pwr_guard_chk #(.REC_CYCLES(REC_CYCLES)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .reg_block_o(reg_block_o),
  .rst_o      (rst_o),
  .mem_ce_n_o (mem_ce_n_o),
  .bat_sel_o  (bat_sel_o),
  .out_en_o   (out_en_o),
  .state_o    (state_o)
);

// File: tb/pwr_guard_tb_top.sv
module pwr_guard_tb_top;
  localparam int REC = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pf = 1'b0, so = 1'b0, ce_n = 1'b1;
  logic reg_block, rst_out, ce_n_out, bat_sel, out_en;
  logic [1:0] state;

  int checks = 0, errors = 0;
  bit run_chk = 1'b0;

  always #2 clk = ~clk;

  pwr_guard #(.REC_CYCLES(REC), .SYNC_STAGES(2)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .pfail_i(pf), .swover_i(so),
    .mem_ce_n_i(ce_n), .reg_block_o(reg_block), .rst_o(rst_out),
    .mem_ce_n_o(ce_n_out), .bat_sel_o(bat_sel), .out_en_o(out_en),
    .state_o(state)
  );

  // reference model: 0 normal, 1 protect, 2 battery, 3 recover
  logic m1p, m2p, m1s, m2s;
  int   m_state, m_spent;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m1p <= 0; m2p <= 0; m1s <= 0; m2s <= 0; m_state <= 0; m_spent <= 0;
    end else begin
      int ns, sp;
      ns = m_state; sp = m_spent;
      case (m_state)
        0: if (m2s) ns = 2; else if (m2p) ns = 1;
        1: if (m2s) ns = 2; else if (!m2p) ns = 3;
        2: if (!m2s) ns = m2p ? 1 : 3;
        default: if (m2s) ns = 2; else if (m2p) ns = 1;
                 else if (m_spent >= REC) ns = 0;
      endcase
      if (ns == 3) sp = (m_state == 3) ? m_spent + 1 : 1;
      else sp = 0;
      m_state <= ns; m_spent <= sp;
      m1p <= pf; m2p <= m1p; m1s <= so; m2s <= m1s;
    end
  end

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic check_all();
    bit prot;
    prot = (m_state != 0);
    chk(state == 2'(m_state), "R7/R8 state", int'(state), m_state);
    chk(reg_block == prot, "R2 reg_block", int'(reg_block), int'(prot));
    chk(rst_out == prot, "R3 rst", int'(rst_out), int'(prot));
    chk(ce_n_out == (prot | ce_n), "R4 ce_n", int'(ce_n_out), int'(prot | ce_n));
    chk(bat_sel == (m_state == 2), "R5/R9 bat_sel", int'(bat_sel), int'(m_state == 2));
    chk(out_en == (m_state != 2), "R6 out_en", int'(out_en), int'(m_state != 2));
  endtask

  always @(negedge clk) if (rst_n && run_chk) check_all();

  task automatic wait_state(int s, output bit seen);
    seen = 0;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (state == 2'(s)) begin seen = 1; break; end
    end
  endtask

  task automatic count_state(int s, output int n);
    n = 0;
    while (state == 2'(s) && n < 1000) begin n++; @(negedge clk); end
  endtask

  initial begin
    bit seen;
    int n;
    void'($urandom(32'd4711));
    // R1: reset state with chip-enable pass-through
    ce_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(state == 2'd0, "R1 state", int'(state), 0);
    chk(reg_block == 0 && rst_out == 0, "R1 block/rst", int'({reg_block, rst_out}), 0);
    chk(bat_sel == 0 && out_en == 1, "R1 bat/out_en", int'({bat_sel, out_en}), 1);
    chk(ce_n_out == 0, "R1 ce pass", int'(ce_n_out), 0);
    ce_n = 1'b1;
    @(negedge clk);
    chk(ce_n_out == 1, "R1 ce pass", int'(ce_n_out), 1);
    rst_n = 1'b1;
    run_chk = 1'b1;
    repeat (2) @(negedge clk);

    // R2: three-edge latency into PROTECT
    pf = 1'b1;
    repeat (2) @(negedge clk);
    chk(state == 2'd0, "R2 not yet", int'(state), 0);
    @(negedge clk);
    chk(state == 2'd1 && reg_block, "R2 protect", int'(state), 1);
    repeat (5) @(negedge clk);
    // R7: full recovery interval
    pf = 1'b0;
    wait_state(3, seen);
    chk(seen, "R7 enter recover", int'(seen), 1);
    count_state(3, n);
    chk(n == REC, "R7 recover length", n, REC);
    chk(state == 2'd0, "R7 back normal", int'(state), 0);

    // R8: failure inside recovery restarts
    pf = 1'b1; repeat (6) @(negedge clk); pf = 1'b0;
    wait_state(3, seen);
    repeat (REC / 2) @(negedge clk);
    chk(state == 2'd3 && rst_out, "R8 mid recover", int'(state), 3);
    pf = 1'b1; @(negedge clk); pf = 1'b0;
    wait_state(1, seen);
    chk(seen, "R8 back to protect", int'(state), 1);
    wait_state(3, seen);
    count_state(3, n);
    chk(n == REC, "R8 full restart length", n, REC);

    // R5/R9: switchover clears while power-fail held
    pf = 1'b1; so = 1'b1;
    repeat (6) @(negedge clk);
    chk(bat_sel && !out_en && state == 2'd2, "R5 battery", int'(state), 2);
    so = 1'b0;
    repeat (3) @(negedge clk);
    chk(!bat_sel && state == 2'd1, "R9 bat drop pf held", int'(state), 1);
    // R9: switchover clears straight into recovery
    so = 1'b1; repeat (6) @(negedge clk);
    so = 1'b0; pf = 1'b0;
    repeat (3) @(negedge clk);
    chk(!bat_sel && state == 2'd3, "R9 bat drop to recover", int'(state), 3);
    repeat (REC + 4) @(negedge clk);

    // random segments
    for (int seg = 0; seg < 400; seg++) begin
      int hold, r;
      r = int'($urandom_range(0, 9));
      pf = (r > 3);
      so = (r > 7) || (r == 0);
      hold = int'($urandom_range(1, 30));
      for (int c = 0; c < hold; c++) begin
        ce_n = 1'($urandom_range(0, 1));
        @(negedge clk);
      end
    end
    pf = 1'b0; so = 1'b0;
    repeat (REC + 6) @(negedge clk);
    chk(state == 2'd0, "R7 final normal", int'(state), 0);

    run_chk = 1'b0;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(4 * 200000);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule